// File: doc/BRIEF.md
# Fault-Test Operation Register Decoder

This block takes 6-bit maintenance operation codes, one at a time, and turns each one into the control actions it stands for. Each code is paired with the 32-bit word currently held in the shift/output register (SOR). The block keeps one binary trigger flip-flop. Some codes set, clear or toggle the trigger, and the conditional branch code tests it. Other codes pick a microprogram data-register group to be merged into the SOR, or hand an SOR field to the microprogram address register. One code resets the error register, and one freezes the storage address clock until an operator presses start. The high-order scan codes are flagged so the scan path can select the wide register group and its fold half.

Op codes arrive on a valid/ready channel. A code is taken on a rising clock edge where both `op_valid` and `op_ready` are high, and `sor_data` is sampled on that same edge. The block lowers `op_ready` only while the storage address clock is inhibited. The sender must then hold its code and valid until ready returns, and no code is lost or duplicated. Every result shows on the outputs during the cycle that follows the accepting edge. Pulse outputs last exactly that one cycle. SOR bit numbering follows the maintenance convention: SOR bit 0 is `sor_data[31]` and SOR bit 31 is `sor_data[0]`.

Top module: `flt_opreg_ctl`

## Requirements
- R1: After synchronous reset `bin_tgr`, `sar_inhibit` and every pulse output (`grp_sel`, `ros_enter`, `err_reset`, `iar_load`, `scan_go`) are 0, and `op_ready` is 1.
- R2: A code is accepted only on an edge with `op_valid` and `op_ready` both high. Its pulses appear in the following cycle and are gone one cycle later.
- R3: Codes 0x01 to 0x04 raise exactly one bit of `grp_sel`, bit index equal to code minus 1, to merge that data-register group with the next storage word.
- R4: Code 0x06 pulses `ros_enter`, sets `roar_addr` to SOR bits 19-30 (`sor_data[12:1]`), and clears the trigger.
- R5: Code 0x07 pulses `err_reset` and clears the trigger.
- R6: Code 0x0E toggles the trigger when all 32 SOR bits are 1, and leaves it unchanged otherwise.
- R7: Code 0x0D with the trigger at 0 pulses `iar_load` with `iar_target` = SOR bits 12-31 (`sor_data[19:0]`) plus 4, modulo 2^20. With the trigger at 1 it loads nothing.
- R8: Code 0x0A raises `sar_inhibit` and drops `op_ready` from the next cycle on. Both are restored on the edge after `start_pb` is sampled high. Codes offered in between are not taken and have no effect.
- R9: Scan codes 0x0C, 0x10-0x1F, 0x31 and 0x35-0x37 pulse `scan_go`, with `scan_hi` = 1 for codes above 0x0F and `scan_fold` = code bit 5.
- R10: Codes 0x00 and 0x08, and every code not named in R3-R9, raise no output and leave the trigger unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Op code offered |
| op_ready | output | 1 | Op code can be taken (low while clock inhibited) |
| op_code | input | 6 | Maintenance op code |
| sor_data | input | 32 | SOR contents, SOR bit 0 on bit 31 |
| start_pb | input | 1 | Start pushbutton, releases the clock inhibit |
| grp_sel | output | 4 | One-hot data-register group to merge into SOR |
| ros_enter | output | 1 | Request microprogram mode, load address register |
| roar_addr | output | 12 | Microprogram address loaded by code 0x06 |
| err_reset | output | 1 | Reset the error register |
| iar_load | output | 1 | Load instruction address register (branch taken) |
| iar_target | output | 20 | Branch address plus 4 |
| bin_tgr | output | 1 | Binary trigger state |
| sar_inhibit | output | 1 | Storage address clock held |
| scan_go | output | 1 | Scan code issued |
| scan_hi | output | 1 | Scan selects high-order group |
| scan_fold | output | 1 | Scan selects fold half of a 36-bit register |

## Verification
The bench tests the branch against both trigger states. A design that ignored the trigger would load the address register after the trigger had been stepped. The target is placed so that adding 4 wraps past the top of the 20-bit field, which exposes a missing increment or a wrong field slice. The toggle is tried with one SOR bit clear, where a faulty design steps anyway, and codes are offered during the clock inhibit, where a design that kept ready high would act on them. Undefined codes close to defined ones (0x05, 0x09, 0x20, 0x3F) show any decode that is too loose.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int OP_W     = 6;
  localparam int SOR_W    = 32;
  localparam int GROUPS   = 4;

  localparam logic [OP_W-1:0] OP_NOP0   = 6'h00;
  localparam logic [OP_W-1:0] OP_GRP1   = 6'h01;
  localparam logic [OP_W-1:0] OP_ROS    = 6'h06;
  localparam logic [OP_W-1:0] OP_ERRCLR = 6'h07;
  localparam logic [OP_W-1:0] OP_HOLD   = 6'h0A;
  localparam logic [OP_W-1:0] OP_SCANLO = 6'h0C;
  localparam logic [OP_W-1:0] OP_BRANCH = 6'h0D;
  localparam logic [OP_W-1:0] OP_STEP   = 6'h0E;

  typedef struct packed {
    logic [GROUPS-1:0] grp;
    logic              ros;
    logic              err;
    logic              branch;
    logic              step;
    logic              hold;
    logic              scan;
    logic              clr_tgr;
  } flt_act_t;
endpackage

// File: rtl/flt_op_decode.sv
module flt_op_decode
  import flt_pkg::*;
#(
  parameter int CODE_W = OP_W,
  parameter int NGRP   = GROUPS
) (
  input  logic [CODE_W-1:0] code,
  output flt_act_t          act,
  output logic              hi,
  output logic              fold
);
  logic scan_lo, scan_hi_band, scan_fold_band;

  always_comb begin
    act = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (code == OP_GRP1 + CODE_W'(g)) act.grp[g] = 1'b1;
    end
    act.ros     = (code == OP_ROS);
    act.err     = (code == OP_ERRCLR);
    act.clr_tgr = (code == OP_ROS) || (code == OP_ERRCLR);
    act.hold    = (code == OP_HOLD);
    act.branch  = (code == OP_BRANCH);
    act.step    = (code == OP_STEP);
    scan_lo        = (code == OP_SCANLO);
    scan_hi_band   = (code[5:4] == 2'b01);
    scan_fold_band = (code == 6'h31) || (code[5:2] == 4'b1101 && code[1:0] != 2'b00);
    act.scan    = scan_lo || scan_hi_band || scan_fold_band;
    hi          = scan_hi_band || scan_fold_band;
    fold        = scan_fold_band;
  end
endmodule

// File: rtl/flt_trigger.sv
module flt_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] word,
  output logic         q
);
  logic ones;
  assign ones = &word;

  always_ff @(posedge clk) begin
    if (rst)              q <= 1'b0;
    else if (clr)         q <= 1'b0;
    else if (step && ones) q <= ~q;
  end
endmodule

// File: rtl/flt_hold.sv
module flt_hold (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic start,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)                held <= 1'b0;
    else if (enter)         held <= 1'b1;
    else if (held && start) held <= 1'b0;
  end
endmodule

// File: rtl/flt_opreg_ctl.sv
module flt_opreg_ctl
  import flt_pkg::*;
#(
  parameter int ROAR_W     = 12,
  parameter int ROAR_LSB   = 1,
  parameter int IAR_W      = 20,
  parameter int BRANCH_INC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [OP_W-1:0]   op_code,
  input  logic [SOR_W-1:0]  sor_data,
  input  logic              start_pb,
  output logic [GROUPS-1:0] grp_sel,
  output logic              ros_enter,
  output logic [ROAR_W-1:0] roar_addr,
  output logic              err_reset,
  output logic              iar_load,
  output logic [IAR_W-1:0]  iar_target,
  output logic              bin_tgr,
  output logic              sar_inhibit,
  output logic              scan_go,
  output logic              scan_hi,
  output logic              scan_fold
);
  localparam int ROAR_MSB = ROAR_LSB + ROAR_W - 1;

  flt_act_t act;
  logic     dec_hi, dec_fold, take;

  flt_op_decode #(.CODE_W(OP_W), .NGRP(GROUPS)) u_dec (
    .code(op_code), .act(act), .hi(dec_hi), .fold(dec_fold)
  );

  assign op_ready = ~sar_inhibit;
  assign take     = op_valid & op_ready;

  flt_trigger #(.W(SOR_W)) u_tgr (
    .clk(clk), .rst(rst),
    .clr(take & act.clr_tgr),
    .step(take & act.step),
    .word(sor_data),
    .q(bin_tgr)
  );

  flt_hold u_hold (
    .clk(clk), .rst(rst),
    .enter(take & act.hold),
    .start(start_pb),
    .held(sar_inhibit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_sel   <= '0;
      ros_enter <= 1'b0;
      err_reset <= 1'b0;
      iar_load  <= 1'b0;
      scan_go   <= 1'b0;
      scan_hi   <= 1'b0;
      scan_fold <= 1'b0;
    end else begin
      grp_sel   <= take ? act.grp : '0;
      ros_enter <= take & act.ros;
      err_reset <= take & act.err;
      iar_load  <= take & act.branch & ~bin_tgr;
      scan_go   <= take & act.scan;
      scan_hi   <= take & act.scan & dec_hi;
      scan_fold <= take & act.scan & dec_fold;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      roar_addr  <= '0;
      iar_target <= '0;
    end else begin
      if (take && act.ros)
        roar_addr <= sor_data[ROAR_MSB:ROAR_LSB];
      if (take && act.branch && !bin_tgr)
        iar_target <= sor_data[IAR_W-1:0] + IAR_W'(BRANCH_INC);
    end
  end
endmodule

// File: rtl/flt_opreg_ctl_chk.sv
module flt_opreg_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_ready,
  input logic [3:0] grp_sel,
  input logic       ros_enter,
  input logic       err_reset,
  input logic       iar_load,
  input logic       bin_tgr,
  input logic       sar_inhibit,
  input logic       scan_go,
  input logic       scan_hi,
  input logic       scan_fold
);
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    sar_inhibit |-> !op_ready);
  a_r3_group_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_sel));
  a_r7_branch_trigger_off: assert property (@(posedge clk) disable iff (rst)
    iar_load |-> !bin_tgr);
  a_r5_err_clears_tgr: assert property (@(posedge clk) disable iff (rst)
    err_reset |-> !bin_tgr);
  a_r4_ros_clears_tgr: assert property (@(posedge clk) disable iff (rst)
    ros_enter |-> !bin_tgr);
  a_r9_scan_flags: assert property (@(posedge clk) disable iff (rst)
    (scan_hi || scan_fold) |-> scan_go);
  a_r2_single_action: assert property (@(posedge clk) disable iff (rst)
    $countones({|grp_sel, ros_enter, err_reset, iar_load, scan_go}) <= 1);
endmodule

bind flt_opreg_ctl flt_opreg_ctl_chk u_chk (
  .clk(clk), .rst(rst), .op_ready(op_ready), .grp_sel(grp_sel),
  .ros_enter(ros_enter), .err_reset(err_reset), .iar_load(iar_load),
  .bin_tgr(bin_tgr), .sar_inhibit(sar_inhibit), .scan_go(scan_go),
  .scan_hi(scan_hi), .scan_fold(scan_fold)
);

// File: tb/flt_opreg_ctl_tb_top.sv
module flt_opreg_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [5:0]  op_code = '0;
  logic [31:0] sor_data = '0;
  logic        start_pb = 1'b0;
  logic [3:0]  grp_sel;
  logic        ros_enter, err_reset, iar_load, bin_tgr, sar_inhibit;
  logic        scan_go, scan_hi, scan_fold;
  logic [11:0] roar_addr;
  logic [19:0] iar_target;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_tgr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flt_opreg_ctl dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .sor_data(sor_data), .start_pb(start_pb),
    .grp_sel(grp_sel), .ros_enter(ros_enter), .roar_addr(roar_addr),
    .err_reset(err_reset), .iar_load(iar_load), .iar_target(iar_target),
    .bin_tgr(bin_tgr), .sar_inhibit(sar_inhibit), .scan_go(scan_go),
    .scan_hi(scan_hi), .scan_fold(scan_fold)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] pulses();
    return {grp_sel, ros_enter, err_reset, iar_load, scan_go, sar_inhibit};
  endfunction

  // Offer one code, return at the negedge after the accepting edge.
  task automatic issue(logic [5:0] c, logic [31:0] s);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; sor_data = s;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pulses", 32'(pulses()), 0);
    chk("R1", "bin_tgr", 32'(bin_tgr), 0);
    chk("R1", "op_ready", 32'(op_ready), 1);
  endtask

  task automatic t_groups();
    for (int g = 0; g < 4; g++) begin
      issue(6'(g + 1), 32'h1234_5678);
      chk("R3", "grp_sel", 32'(grp_sel), 32'(1 << g));
      @(negedge clk);
      chk("R2", "pulse gone", 32'(pulses()), 0);
    end
  endtask

  task automatic t_step_and_branch();
    issue(6'h0E, 32'hFFFF_FFFE);
    chk("R6", "no step, one bit clear", 32'(bin_tgr), 0);
    issue(6'h0E, 32'hFFFF_FFFF);
    exp_tgr = 1'b1;
    chk("R6", "step on all ones", 32'(bin_tgr), 32'(exp_tgr));
    issue(6'h0D, 32'h0000_0100);
    chk("R7", "no branch, trigger on", 32'(iar_load), 0);
    issue(6'h07, 32'h0);
    exp_tgr = 1'b0;
    chk("R5", "err_reset", 32'(err_reset), 1);
    chk("R5", "trigger cleared", 32'(bin_tgr), 0);
    issue(6'h0D, 32'hABCF_FFFE);
    chk("R7", "branch taken", 32'(iar_load), 1);
    chk("R7", "target wraps", 32'(iar_target), 32'h0_0002);
    @(negedge clk);
    chk("R2", "iar_load one cycle", 32'(iar_load), 0);
  endtask

  task automatic t_ros();
    issue(6'h0E, 32'hFFFF_FFFF);
    chk("R6", "trigger set again", 32'(bin_tgr), 1);
    issue(6'h06, 32'h0000_1ACB);
    chk("R4", "ros_enter", 32'(ros_enter), 1);
    chk("R4", "roar_addr", 32'(roar_addr), 32'h0D65);
    chk("R4", "trigger cleared", 32'(bin_tgr), 0);
  endtask

  task automatic t_hold();
    issue(6'h0A, 32'h0);
    chk("R8", "sar_inhibit", 32'(sar_inhibit), 1);
    chk("R8", "ready low", 32'(op_ready), 0);
    op_valid = 1'b1; op_code = 6'h0E; sor_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    chk("R8", "held code ignored, trigger", 32'(bin_tgr), 0);
    chk("R8", "still held", 32'(sar_inhibit), 1);
    start_pb = 1'b1;
    @(negedge clk);
    start_pb = 1'b0;
    chk("R8", "released", 32'(sar_inhibit), 0);
    chk("R8", "ready back", 32'(op_ready), 1);
  endtask

  task automatic t_scan();
    issue(6'h0C, 32'h0);
    chk("R9", "0C flags", 32'({scan_go, scan_hi, scan_fold}), 32'b100);
    issue(6'h1A, 32'h0);
    chk("R9", "1A flags", 32'({scan_go, scan_hi, scan_fold}), 32'b110);
    issue(6'h36, 32'h0);
    chk("R9", "36 flags", 32'({scan_go, scan_hi, scan_fold}), 32'b111);
  endtask

  task automatic t_nops();
    logic [5:0] codes [6] = '{6'h00, 6'h08, 6'h05, 6'h09, 6'h20, 6'h3F};
    issue(6'h0E, 32'hFFFF_FFFF);
    exp_tgr = 1'b1;
    foreach (codes[i]) begin
      issue(codes[i], 32'hFFFF_FFFF);
      chk("R10", "no outputs", 32'({pulses(), scan_hi, scan_fold}), 0);
      chk("R10", "trigger kept", 32'(bin_tgr), 32'(exp_tgr));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_groups();
    t_step_and_branch();
    t_ros();
    t_hold();
    t_scan();
    t_nops();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule